// File: doc/BRIEF.md
# Shadowed Two-Channel Control Register Bank

This block holds the control registers of a two-channel converter. It is reached through a byte-wide port that has already been decoded: an address, write data, a write strobe and a read strobe. Three configuration registers take effect as soon as they are written. A channel index register steers accesses to registers that exist once per channel. A transfer register commits staged settings. A band of program registers is written into pending (shadow) storage and reaches the converter only when software commits it.

Some program registers are kept once per channel (local) and the others are shared (global). The index register chooses which channel copies a local write lands in. It also chooses which copy a local read returns, with a fixed priority when more than one channel is selected. Global registers take no notice of the index. Reads are combinational and return zero while the read strobe is low.

Top module: `rmap_top`

## Requirements
- R1: After reset the registers read: 0x00=0x18, 0x01=0x00, 0x02=0x05, index 0x05=0x03, transfer 0xFF=0x00, local 0x08=0x00, local 0x14=0x01, global 0x22=0x02, global 0x38=0x00. The active outputs hold these same program values.
- R2: A write to a program register (0x08, 0x14, 0x22, 0x38) changes only its pending copy. A read returns the pending value, and the active outputs stay unchanged.
- R3: A write to 0xFF with data bit 0 set copies every pending program register into its active copy at the next clock edge. A write to 0xFF with bit 0 clear commits nothing.
- R4: The transfer bit reads back as 0x01 during the cycle that follows the commit write. It clears by itself at the next edge and from then on reads 0x00.
- R5: In the index register, bit 0 selects channel 1 and bit 1 selects channel 2. Bits 7:2 read as 0.
- R6: With both index bits set, a local write updates the pending copies of both channels.
- R7: A local read returns the channel 2 copy only when the index is exactly 0b10. For any other index value (0b01, 0b11 or 0b00) it returns the channel 1 copy.
- R8: A local write while both index bits are clear changes neither channel's copy.
- R9: Global registers are written and read the same way whatever the index holds.
- R10: Addresses outside the map ignore writes and read 0x00. Implemented field masks are 0x00:0x3C, 0x01:0xFF, 0x02:0x0F, 0x08:0x03, 0x14:0x3F, 0x22:0x07 and 0x38:0xFF. Bits outside a mask read 0 and are never stored.
- R11: Configuration registers 0x00 to 0x02 appear on cfg_o straight after the write edge, without a transfer.
- R12: rdata_o is 0x00 whenever rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Combinational read data |
| cfg_o | output | 24 | Configuration registers, byte k = register k |
| loc_act_o | output | 32 | Active local registers, byte (c*2+k) = channel c, local k (0x08, 0x14) |
| glb_act_o | output | 16 | Active global registers, byte k = global k (0x22, 0x38) |

## Verification
A corrupted pending copy shows up at once on a read of that address. In the active copy it appears only after the next commit, so every staging check is followed by a commit and a check of the packed outputs on the cycle after the transfer edge. If the index is steered wrongly, a value lands in the wrong channel. That mistake stays hidden until the other channel is read back or committed, which is why each index case reads both channels. A transfer bit that is stuck shows on the 0xFF read one cycle later.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
    localparam int DW   = 8;
    localparam int AW   = 8;
    localparam int NCH  = 2;
    localparam int NCFG = 3;
    localparam int NLOC = 2;
    localparam int NGLB = 2;

    localparam logic [AW-1:0] CFG_ADDR [NCFG] = '{8'h00, 8'h01, 8'h02};
    localparam logic [DW-1:0] CFG_MASK [NCFG] = '{8'h3C, 8'hFF, 8'h0F};
    localparam logic [DW-1:0] CFG_RST  [NCFG] = '{8'h18, 8'h00, 8'h05};

    localparam logic [AW-1:0] IDX_ADDR  = 8'h05;
    localparam logic [AW-1:0] XFER_ADDR = 8'hFF;
    localparam logic [NCH-1:0] IDX_RST  = '1;

    localparam logic [AW-1:0] LOC_ADDR [NLOC] = '{8'h08, 8'h14};
    localparam logic [DW-1:0] LOC_MASK [NLOC] = '{8'h03, 8'h3F};
    localparam logic [DW-1:0] LOC_RST  [NLOC] = '{8'h00, 8'h01};

    localparam logic [AW-1:0] GLB_ADDR [NGLB] = '{8'h22, 8'h38};
    localparam logic [DW-1:0] GLB_MASK [NGLB] = '{8'h07, 8'hFF};
    localparam logic [DW-1:0] GLB_RST  [NGLB] = '{8'h02, 8'h00};

    typedef struct packed {
        logic [NLOC-1:0][DW-1:0] shd;
        logic [NLOC-1:0][DW-1:0] act;
    } chan_st_t;

    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] cfg;
        logic [NCH-1:0]          idx;
        logic                    xfer;
        logic [NGLB-1:0][DW-1:0] shd;
        logic [NGLB-1:0][DW-1:0] act;
    } glob_st_t;

    function automatic chan_st_t chan_reset();
        chan_st_t s;
        for (int k = 0; k < NLOC; k++) begin
            s.shd[k] = LOC_RST[k];
            s.act[k] = LOC_RST[k];
        end
        return s;
    endfunction

    function automatic glob_st_t glob_reset();
        glob_st_t s;
        for (int k = 0; k < NCFG; k++) s.cfg[k] = CFG_RST[k];
        s.idx  = IDX_RST;
        s.xfer = 1'b0;
        for (int k = 0; k < NGLB; k++) begin
            s.shd[k] = GLB_RST[k];
            s.act[k] = GLB_RST[k];
        end
        return s;
    endfunction
endpackage

// File: rtl/rmap_decode.sv
module rmap_decode
    import rmap_pkg::*;
(
    input  logic [AW-1:0]   addr_i,
    output logic [NCFG-1:0] hit_cfg_o,
    output logic            hit_idx_o,
    output logic            hit_xfer_o,
    output logic [NLOC-1:0] hit_loc_o,
    output logic [NGLB-1:0] hit_glb_o,
    output logic            hit_any_o
);
    for (genvar k = 0; k < NCFG; k++) begin : g_cfg
        assign hit_cfg_o[k] = (addr_i == CFG_ADDR[k]);
    end
    for (genvar k = 0; k < NLOC; k++) begin : g_loc
        assign hit_loc_o[k] = (addr_i == LOC_ADDR[k]);
    end
    for (genvar k = 0; k < NGLB; k++) begin : g_glb
        assign hit_glb_o[k] = (addr_i == GLB_ADDR[k]);
    end
    assign hit_idx_o  = (addr_i == IDX_ADDR);
    assign hit_xfer_o = (addr_i == XFER_ADDR);
    assign hit_any_o  = |{hit_cfg_o, hit_idx_o, hit_xfer_o, hit_loc_o, hit_glb_o};
endmodule

// File: rtl/rmap_chan.sv
module rmap_chan
    import rmap_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic [NLOC-1:0]         hit_loc_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic                    commit_i,
    output logic [NLOC-1:0][DW-1:0] shd_o,
    output logic [NLOC-1:0][DW-1:0] act_o
);
    localparam chan_st_t RST_V = chan_reset();
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NLOC; k++) begin
            if (wr_en_i && hit_loc_i[k]) st_d.shd[k] = wdata_i & LOC_MASK[k];
        end
        if (commit_i) st_d.act = st_q.shd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_V;
        else        st_q <= st_d;
    end

    assign shd_o = st_q.shd;
    assign act_o = st_q.act;

    // R2
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(act_o));
    // R3
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (act_o == $past(shd_o)));
endmodule

// File: rtl/rmap_glob.sv
module rmap_glob
    import rmap_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [NCFG-1:0]         hit_cfg_i,
    input  logic                    hit_idx_i,
    input  logic                    hit_xfer_i,
    input  logic [NGLB-1:0]         hit_glb_i,
    output logic [NCFG-1:0][DW-1:0] cfg_o,
    output logic [NCH-1:0]          idx_o,
    output logic                    xfer_o,
    output logic [NGLB-1:0][DW-1:0] shd_o,
    output logic [NGLB-1:0][DW-1:0] act_o
);
    localparam glob_st_t RST_V = glob_reset();
    glob_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NCFG; k++) begin
            if (wr_i && hit_cfg_i[k]) st_d.cfg[k] = wdata_i & CFG_MASK[k];
        end
        if (wr_i && hit_idx_i) st_d.idx = wdata_i[NCH-1:0];
        for (int k = 0; k < NGLB; k++) begin
            if (wr_i && hit_glb_i[k]) st_d.shd[k] = wdata_i & GLB_MASK[k];
        end
        st_d.xfer = wr_i && hit_xfer_i && wdata_i[0];
        if (st_q.xfer) st_d.act = st_q.shd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_V;
        else        st_q <= st_d;
    end

    assign cfg_o  = st_q.cfg;
    assign idx_o  = st_q.idx;
    assign xfer_o = st_q.xfer;
    assign shd_o  = st_q.shd;
    assign act_o  = st_q.act;

    // R4
    xfer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && !(wr_i && hit_xfer_i)) |=> !xfer_o);
    // R2
    glb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_o |=> $stable(act_o));
endmodule

// File: rtl/rmap_top.sv
module rmap_top
    import rmap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    input  logic                wr_i,
    input  logic                rd_i,
    output logic [DW-1:0]       rdata_o,
    output logic [NCFG*DW-1:0]  cfg_o,
    output logic [NCH*NLOC*DW-1:0] loc_act_o,
    output logic [NGLB*DW-1:0]  glb_act_o
);
    logic [NCFG-1:0] hit_cfg;
    logic            hit_idx, hit_xfer, hit_any;
    logic [NLOC-1:0] hit_loc;
    logic [NGLB-1:0] hit_glb;

    logic [NCFG-1:0][DW-1:0] cfg_q;
    logic [NCH-1:0]          idx_q;
    logic                    xfer_q;
    logic [NGLB-1:0][DW-1:0] gshd, gact;
    logic [NLOC-1:0][DW-1:0] ch_shd [NCH];
    logic [NLOC-1:0][DW-1:0] ch_act [NCH];

    rmap_decode u_dec (
        .addr_i    (addr_i),
        .hit_cfg_o (hit_cfg),
        .hit_idx_o (hit_idx),
        .hit_xfer_o(hit_xfer),
        .hit_loc_o (hit_loc),
        .hit_glb_o (hit_glb),
        .hit_any_o (hit_any)
    );

    rmap_glob u_glb (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_i),
        .wdata_i   (wdata_i),
        .hit_cfg_i (hit_cfg),
        .hit_idx_i (hit_idx),
        .hit_xfer_i(hit_xfer),
        .hit_glb_i (hit_glb),
        .cfg_o     (cfg_q),
        .idx_o     (idx_q),
        .xfer_o    (xfer_q),
        .shd_o     (gshd),
        .act_o     (gact)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rmap_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en_i  (wr_i && idx_q[c]),
            .hit_loc_i(hit_loc),
            .wdata_i  (wdata_i),
            .commit_i (xfer_q),
            .shd_o    (ch_shd[c]),
            .act_o    (ch_act[c])
        );
        for (genvar k = 0; k < NLOC; k++) begin : g_out
            assign loc_act_o[(c*NLOC+k)*DW +: DW] = ch_act[c][k];
        end
    end

    for (genvar k = 0; k < NCFG; k++) begin : g_cfg_out
        assign cfg_o[k*DW +: DW] = cfg_q[k];
    end
    for (genvar k = 0; k < NGLB; k++) begin : g_glb_out
        assign glb_act_o[k*DW +: DW] = gact[k];
    end

    // Lowest selected channel wins a local read; none selected falls back to channel 1.
    logic [$clog2(NCH)-1:0] rd_ch;
    logic [DW-1:0]          rd_val;

    always_comb begin
        rd_ch = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (idx_q[c]) rd_ch = c[$clog2(NCH)-1:0];
        end
        rd_val = '0;
        for (int k = 0; k < NCFG; k++) if (hit_cfg[k]) rd_val = cfg_q[k];
        for (int k = 0; k < NLOC; k++) if (hit_loc[k]) rd_val = ch_shd[rd_ch][k];
        for (int k = 0; k < NGLB; k++) if (hit_glb[k]) rd_val = gshd[k];
        if (hit_idx)  rd_val = DW'(idx_q);
        if (hit_xfer) rd_val = DW'(xfer_q);
    end

    assign rdata_o = rd_i ? rd_val : '0;

    // R8
    no_chan_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (|hit_loc) && (idx_q == '0)) |=> ($stable(ch_shd[0]) && $stable(ch_shd[1])));
    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !hit_any) |-> (rdata_o == '0));
endmodule

// File: tb/sim_rmap_top.sv
`timescale 1ns/1ps
module sim_rmap_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [7:0]  rdata_o;
    logic [23:0] cfg_o;
    logic [31:0] loc_act_o;
    logic [15:0] glb_act_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rmap_top u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .cfg_o(cfg_o),
        .loc_act_o(loc_act_o), .glb_act_o(glb_act_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr_i = a; rd_i = 1'b1;
        #0.5;
        d = rdata_o;
        rd_i = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic commit();
        wr(8'hFF, 8'h01);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rdchk("R1 cfg0", 8'h00, 8'h18);
        rdchk("R1 cfg1", 8'h01, 8'h00);
        rdchk("R1 cfg2", 8'h02, 8'h05);
        rdchk("R1 idx", 8'h05, 8'h03);
        rdchk("R1 xfer", 8'hFF, 8'h00);
        rdchk("R1 loc0", 8'h08, 8'h00);
        rdchk("R1 loc1", 8'h14, 8'h01);
        rdchk("R1 glb0", 8'h22, 8'h02);
        rdchk("R1 glb1", 8'h38, 8'h00);
        chk("R1 loc_act", loc_act_o, 32'h0100_0100);
        chk("R1 glb_act", {16'h0, glb_act_o}, 32'h0002);
        chk("R1 cfg_o", {8'h0, cfg_o}, 32'h05_0018);
    endtask

    task automatic t_shadow_hold();
        wr(8'h14, 8'h2A);
        wr(8'h38, 8'h5C);
        rdchk("R2 loc1 pending", 8'h14, 8'h2A);
        rdchk("R2 glb1 pending", 8'h38, 8'h5C);
        chk("R2 loc_act held", loc_act_o, 32'h0100_0100);
        chk("R2 glb_act held", {16'h0, glb_act_o}, 32'h0002);
    endtask

    task automatic t_commit();
        wr(8'hFF, 8'h00);
        @(negedge clk);
        chk("R3 no commit on bit0 clear", loc_act_o, 32'h0100_0100);
        rdchk("R4 xfer idle", 8'hFF, 8'h00);
        wr(8'hFF, 8'h01);
        rdchk("R4 xfer set", 8'hFF, 8'h01);
        @(negedge clk);
        rdchk("R4 xfer cleared", 8'hFF, 8'h00);
        chk("R3 loc_act committed", loc_act_o, 32'h2A00_2A00);
        chk("R3 glb_act committed", {16'h0, glb_act_o}, 32'h5C02);
    endtask

    task automatic t_index();
        wr(8'h05, 8'hFD);
        rdchk("R5 idx masked", 8'h05, 8'h01);
        wr(8'h08, 8'hFF);
        wr(8'h05, 8'h02);
        wr(8'h08, 8'h02);
        rdchk("R5 ch2 read", 8'h08, 8'h02);
        wr(8'h05, 8'h01);
        rdchk("R5 ch1 read", 8'h08, 8'h03);
        wr(8'h05, 8'h03);
        rdchk("R7 both selects ch1", 8'h08, 8'h03);
        wr(8'h14, 8'h11);
        wr(8'h05, 8'h02);
        rdchk("R6 both written ch2", 8'h14, 8'h11);
        wr(8'h05, 8'h00);
        wr(8'h08, 8'h01);
        rdchk("R7 none selects ch1", 8'h08, 8'h03);
        wr(8'h05, 8'h02);
        rdchk("R8 ch2 untouched", 8'h08, 8'h02);
        commit();
        chk("R6 R8 committed channels", loc_act_o, 32'h1102_1103);
    endtask

    task automatic t_global();
        wr(8'h05, 8'h00);
        wr(8'h22, 8'hFF);
        rdchk("R9 glb idx none", 8'h22, 8'h07);
        wr(8'h05, 8'h02);
        rdchk("R9 glb idx ch2", 8'h22, 8'h07);
        commit();
        chk("R9 glb committed", {16'h0, glb_act_o}, 32'h5C07);
    endtask

    task automatic t_unmapped();
        wr(8'h13, 8'hAA);
        rdchk("R10 unmapped 0x13", 8'h13, 8'h00);
        rdchk("R10 unmapped 0x03", 8'h03, 8'h00);
        chk("R10 outputs unchanged", loc_act_o, 32'h1102_1103);
        wr(8'h00, 8'hFF);
        rdchk("R10 cfg0 mask", 8'h00, 8'h3C);
    endtask

    task automatic t_cfg();
        chk("R11 cfg0 immediate", {24'h0, cfg_o[7:0]}, 32'h3C);
        wr(8'h01, 8'h9E);
        chk("R11 cfg1 immediate", {24'h0, cfg_o[15:8]}, 32'h9E);
    endtask

    task automatic t_rd_idle();
        addr_i = 8'h00; rd_i = 1'b0;
        #0.5;
        chk("R12 idle read zero", {24'h0, rdata_o}, 32'h0);
    endtask

    initial begin
        #0.5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shadow_hold();
        t_commit();
        t_index();
        t_global();
        t_unmapped();
        t_cfg();
        t_rd_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule